// File: doc/BRIEF.md
# Toggle-Bit Mailbox and Interrupt Controller

This block lets a host side and a local CPU side pass short messages to each other through a set of mailbox registers. A message carries a 31-bit payload in bits [30:0] and a sequence bit in bit 31. A receiver is interrupted only when the sender flips the sequence bit. Writing the same sequence value again changes the payload and raises nothing. Each direction also has a 32-bit extension word. The writer stages it first. It is copied into a shadow register at the moment the main word's sequence bit flips, so the reader always sees a payload and extension written together.

Two short power-message registers follow the same rule. The host writes an 8-bit one whose sequence bit is bit 7; it resets to 0x07. The CPU writes a 16-bit one whose sequence bit is bit 15.

Each side has one status register and one mask register. The status register holds a message-event bit and a power-event bit, and writing 1 to a bit clears it. The side's interrupt line is the OR of its status bits ANDed with its mask bits. Each side has a simple synchronous register port: a write strobe, a word address and write data, with combinational read data for the current address. Both sides share one clock.

Top module: `mbx_top`

## Requirements
- R1: After reset, all message, staging and shadow words read 0, the host power register reads 0x07, the CPU power register reads 0, status and mask registers read 0, and both interrupt lines are low.
- R2: Each side's address 0 holds its outgoing message and reads back what it last wrote. The same word reads on the other side at address 2 from the cycle after the write.
- R3: Writes to addresses 2, 3 and 5 on either side are ignored. None of the readable state on either port changes.
- R4: A message write whose bit 31 differs from the stored bit 31 sets bit 0 of the receiving side's status register. This holds for a change from 0 to 1 and for a change from 1 to 0.
- R5: A message write whose bit 31 equals the stored bit 31 updates the payload and leaves the receiver's status unchanged.
- R6: Address 1 is the writer's extension staging word, readable by the writer. The receiver reads the shadow at address 3. The shadow takes the staging value only on a write to address 0 that flips bit 31, and otherwise holds its value.
- R7: Address 4 is the side's own power register: 8 bits with the sequence bit at bit 7 on the host side, and 16 bits with the sequence bit at bit 15 on the CPU side. Upper write bits are dropped. The peer reads it zero-extended at address 5. A flip of its sequence bit sets bit 1 of the peer's status register.
- R8: Address 6 is the side's status register. Writing 1 to a bit clears it and writing 0 keeps it. If a set and a clear of the same bit fall in one cycle, the set wins. Bits 31:2 read 0.
- R9: Address 7 holds the side's 2-bit mask. The side's interrupt is high exactly when some status bit and its mask bit are both 1, so a mask bit of 0 blocks its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 3 | Host word address (read and write) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data for h_addr |
| h_irq | output | 1 | Interrupt to host |
| c_we | input | 1 | CPU write strobe |
| c_addr | input | 3 | CPU word address (read and write) |
| c_wdata | input | 32 | CPU write data |
| c_rdata | output | 32 | CPU read data for c_addr |
| c_irq | output | 1 | Interrupt to CPU |

## Verification
Message writes in both directions walk a sequence-bit pattern of 0,0,1,1,0,0,1,1 with a different payload and extension each time. This separates a genuine flip from a repeated value, and a rise from a fall. After every operation, all eight addresses on both ports are read back and the interrupt lines are compared with a model. A shadow that copies on every write, or a status that sets on any write, shows up within one step. Power registers are written with junk in the upper bits to expose truncation faults. Every mask value is swept against set status bits. One cycle places a host flip against a CPU clear of the same status bit to check that the set wins.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned NSRC   = 2;
  localparam int unsigned SRC_MSG = 0;
  localparam int unsigned SRC_PWR = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_OWN_MSG  = 3'd0,
    A_OWN_EXT  = 3'd1,
    A_PEER_MSG = 3'd2,
    A_PEER_EXT = 3'd3,
    A_OWN_PWR  = 3'd4,
    A_PEER_PWR = 3'd5,
    A_STAT     = 3'd6,
    A_MASK     = 3'd7
  } reg_sel_e;

  // sequence event: stored and incoming sequence bits disagree
  function automatic logic seq_flipped(input logic stored, input logic incoming);
    return stored ^ incoming;
  endfunction

  // next status: write-1 clears, new events win over clears
  function automatic logic [NSRC-1:0] stat_next(input logic [NSRC-1:0] cur,
                                                input logic [NSRC-1:0] clr,
                                                input logic [NSRC-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/mbx_chan.sv
module mbx_chan
  import mbx_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter bit          HAS_EXT = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_main,
  input  logic              wr_ext,
  input  logic [W-1:0]      wdata,
  input  logic [DATA_W-1:0] ext_wdata,
  output logic [W-1:0]      main_q,
  output logic [DATA_W-1:0] stage_q,
  output logic [DATA_W-1:0] shadow_q,
  output logic              flip
);
  localparam int unsigned SEQ = W - 1;

  assign flip = wr_main && seq_flipped(main_q[SEQ], wdata[SEQ]);

  always_ff @(posedge clk) begin
    if (!rst_n)       main_q <= RST_VAL;
    else if (wr_main) main_q <= wdata;
  end

  generate
    if (HAS_EXT) begin : g_ext
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          stage_q  <= '0;
          shadow_q <= '0;
        end else begin
          if (wr_ext) stage_q  <= ext_wdata;
          if (flip)   shadow_q <= stage_q;
        end
      end
    end else begin : g_noext
      logic unused_ok;
      assign unused_ok = ^{wr_ext, ext_wdata};
      assign stage_q   = '0;
      assign shadow_q  = '0;
    end
  endgenerate
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] mask_q,
  output logic         irq
);
  logic [N-1:0] clr;
  assign clr = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_next(stat_q, clr, set);
      if (mask_we) mask_q <= wdata;
    end
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int unsigned   HPW     = 8,
  parameter int unsigned   CPW     = 16,
  parameter logic [HPW-1:0] HPW_RST = 8'h07
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  output logic [DATA_W-1:0] h_rdata,
  output logic              h_irq,
  input  logic              c_we,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  output logic [DATA_W-1:0] c_rdata,
  output logic              c_irq
);
  localparam logic [CPW-1:0] CPW_RST = '0;

  reg_sel_e h_sel, c_sel;
  assign h_sel = reg_sel_e'(h_addr);
  assign c_sel = reg_sel_e'(c_addr);

  // write decodes
  logic h_msg_we, h_ext_we, h_pwr_we, h_stat_we, h_mask_we;
  logic c_msg_we, c_ext_we, c_pwr_we, c_stat_we, c_mask_we;
  assign h_msg_we  = h_we && (h_sel == A_OWN_MSG);
  assign h_ext_we  = h_we && (h_sel == A_OWN_EXT);
  assign h_pwr_we  = h_we && (h_sel == A_OWN_PWR);
  assign h_stat_we = h_we && (h_sel == A_STAT);
  assign h_mask_we = h_we && (h_sel == A_MASK);
  assign c_msg_we  = c_we && (c_sel == A_OWN_MSG);
  assign c_ext_we  = c_we && (c_sel == A_OWN_EXT);
  assign c_pwr_we  = c_we && (c_sel == A_OWN_PWR);
  assign c_stat_we = c_we && (c_sel == A_STAT);
  assign c_mask_we = c_we && (c_sel == A_MASK);

  // named internal events and state
  logic [DATA_W-1:0] h2c_q, h2c_stage, h2c_shadow;
  logic [DATA_W-1:0] c2h_q, c2h_stage, c2h_shadow;
  logic [HPW-1:0]    hpw_q;
  logic [CPW-1:0]    cpw_q;
  logic [DATA_W-1:0] hpw_stage_nc, hpw_shadow_nc, cpw_stage_nc, cpw_shadow_nc;
  logic h2c_flip, c2h_flip, hpw_flip, cpw_flip;

  mbx_chan #(.W(DATA_W), .HAS_EXT(1'b1), .RST_VAL('0)) u_h2c (
    .clk(clk), .rst_n(rst_n), .wr_main(h_msg_we), .wr_ext(h_ext_we),
    .wdata(h_wdata), .ext_wdata(h_wdata),
    .main_q(h2c_q), .stage_q(h2c_stage), .shadow_q(h2c_shadow), .flip(h2c_flip));

  mbx_chan #(.W(DATA_W), .HAS_EXT(1'b1), .RST_VAL('0)) u_c2h (
    .clk(clk), .rst_n(rst_n), .wr_main(c_msg_we), .wr_ext(c_ext_we),
    .wdata(c_wdata), .ext_wdata(c_wdata),
    .main_q(c2h_q), .stage_q(c2h_stage), .shadow_q(c2h_shadow), .flip(c2h_flip));

  mbx_chan #(.W(HPW), .HAS_EXT(1'b0), .RST_VAL(HPW_RST)) u_hpw (
    .clk(clk), .rst_n(rst_n), .wr_main(h_pwr_we), .wr_ext(1'b0),
    .wdata(h_wdata[HPW-1:0]), .ext_wdata('0),
    .main_q(hpw_q), .stage_q(hpw_stage_nc), .shadow_q(hpw_shadow_nc), .flip(hpw_flip));

  mbx_chan #(.W(CPW), .HAS_EXT(1'b0), .RST_VAL(CPW_RST)) u_cpw (
    .clk(clk), .rst_n(rst_n), .wr_main(c_pwr_we), .wr_ext(1'b0),
    .wdata(c_wdata[CPW-1:0]), .ext_wdata('0),
    .main_q(cpw_q), .stage_q(cpw_stage_nc), .shadow_q(cpw_shadow_nc), .flip(cpw_flip));

  logic unused_nc;
  assign unused_nc = ^{hpw_stage_nc, hpw_shadow_nc, cpw_stage_nc, cpw_shadow_nc};

  // status / mask per receiving side
  logic [NSRC-1:0] h_set, c_set, h_stat, c_stat, h_mask, c_mask;
  assign c_set[SRC_MSG] = h2c_flip;
  assign c_set[SRC_PWR] = hpw_flip;
  assign h_set[SRC_MSG] = c2h_flip;
  assign h_set[SRC_PWR] = cpw_flip;

  mbx_irq #(.N(NSRC)) u_hirq (
    .clk(clk), .rst_n(rst_n), .set(h_set), .clr_we(h_stat_we), .mask_we(h_mask_we),
    .wdata(h_wdata[NSRC-1:0]), .stat_q(h_stat), .mask_q(h_mask), .irq(h_irq));

  mbx_irq #(.N(NSRC)) u_cirq (
    .clk(clk), .rst_n(rst_n), .set(c_set), .clr_we(c_stat_we), .mask_we(c_mask_we),
    .wdata(c_wdata[NSRC-1:0]), .stat_q(c_stat), .mask_q(c_mask), .irq(c_irq));

  // read muxes
  always_comb begin
    unique case (h_sel)
      A_OWN_MSG:  h_rdata = h2c_q;
      A_OWN_EXT:  h_rdata = h2c_stage;
      A_PEER_MSG: h_rdata = c2h_q;
      A_PEER_EXT: h_rdata = c2h_shadow;
      A_OWN_PWR:  h_rdata = DATA_W'(hpw_q);
      A_PEER_PWR: h_rdata = DATA_W'(cpw_q);
      A_STAT:     h_rdata = DATA_W'(h_stat);
      A_MASK:     h_rdata = DATA_W'(h_mask);
      default:    h_rdata = '0;
    endcase
  end

  always_comb begin
    unique case (c_sel)
      A_OWN_MSG:  c_rdata = c2h_q;
      A_OWN_EXT:  c_rdata = c2h_stage;
      A_PEER_MSG: c_rdata = h2c_q;
      A_PEER_EXT: c_rdata = h2c_shadow;
      A_OWN_PWR:  c_rdata = DATA_W'(cpw_q);
      A_PEER_PWR: c_rdata = DATA_W'(hpw_q);
      A_STAT:     c_rdata = DATA_W'(c_stat);
      A_MASK:     c_rdata = DATA_W'(c_mask);
      default:    c_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_we,
  input logic [2:0]  h_addr,
  input logic [31:0] h_wdata,
  input logic        c_we,
  input logic [2:0]  c_addr,
  input logic [31:0] c_wdata,
  input logic        h_irq,
  input logic        c_irq,
  input logic        h2c_flip,
  input logic        c2h_flip,
  input logic [31:0] h2c_q,
  input logic [31:0] h2c_shadow,
  input logic [1:0]  c_stat,
  input logic [1:0]  c_mask,
  input logic [1:0]  h_mask
);
  p_flip_sets_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    h2c_flip |=> c_stat[0]);

  p_c2h_flip_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c2h_flip && h_mask[0]) |=> h_irq);

  p_same_seq_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_we && h_addr == 3'd0 && h_wdata[31] == h2c_q[31] && !c_stat[0]) |=> !c_stat[0]);

  p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !h2c_flip |=> $stable(h2c_shadow));

  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && c_addr == 3'd6 && c_wdata[0] && !h2c_flip) |=> !c_stat[0]);

  p_ro_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_we && c_addr == 3'd2 && !(h_we && h_addr == 3'd0)) |=> $stable(h2c_q));

  p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_mask == 2'b00) |-> !c_irq);
endmodule

bind mbx_top mbx_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata),
  .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
  .h_irq(h_irq), .c_irq(c_irq),
  .h2c_flip(h2c_flip), .c2h_flip(c2h_flip),
  .h2c_q(h2c_q), .h2c_shadow(h2c_shadow),
  .c_stat(c_stat), .c_mask(c_mask), .h_mask(h_mask)
);

// File: tb/sim_mbx_top.sv
module sim_mbx_top;
  localparam time CLK_PER = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_we = 1'b0, c_we = 1'b0;
  logic [2:0]  h_addr = '0, c_addr = '0;
  logic [31:0] h_wdata = '0, c_wdata = '0;
  logic [31:0] h_rdata, c_rdata;
  logic        h_irq, c_irq;

  int total = 0;
  int bad = 0;

  // model state
  logic [31:0] m_h2c = '0, m_h2s = '0, m_h2x = '0;
  logic [31:0] m_c2h = '0, m_c2s = '0, m_c2x = '0;
  logic [7:0]  m_hpw = 8'h07;
  logic [15:0] m_cpw = '0;
  logic [1:0]  hst = '0, cst = '0, hmsk = '0, cmsk = '0;

  always #(CLK_PER/2) clk = ~clk;

  mbx_top u0 (
    .clk(clk), .rst_n(rst_n),
    .h_we(h_we), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_irq(h_irq),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata), .c_irq(c_irq)
  );

  task automatic model_h(input int a, input logic [31:0] d);
    case (a)
      0: begin
        if (d[31] != m_h2c[31]) begin cst[0] = 1'b1; m_h2x = m_h2s; end
        m_h2c = d;
      end
      1: m_h2s = d;
      4: begin
        if (d[7] != m_hpw[7]) cst[1] = 1'b1;
        m_hpw = d[7:0];
      end
      6: hst = hst & ~d[1:0];
      7: hmsk = d[1:0];
      default: ;
    endcase
  endtask

  task automatic model_c(input int a, input logic [31:0] d);
    case (a)
      0: begin
        if (d[31] != m_c2h[31]) begin hst[0] = 1'b1; m_c2x = m_c2s; end
        m_c2h = d;
      end
      1: m_c2s = d;
      4: begin
        if (d[15] != m_cpw[15]) hst[1] = 1'b1;
        m_cpw = d[15:0];
      end
      6: cst = cst & ~d[1:0];
      7: cmsk = d[1:0];
      default: ;
    endcase
  endtask

  task automatic both(input bit hv, input int ha, input logic [31:0] hd,
                      input bit cv, input int ca, input logic [31:0] cd);
    @(negedge clk);
    h_we = hv; h_addr = 3'(ha); h_wdata = hd;
    c_we = cv; c_addr = 3'(ca); c_wdata = cd;
    // clears are applied before sets so that a same-cycle set wins
    if (cv && ca == 6) model_c(ca, cd);
    if (hv && ha == 6) model_h(ha, hd);
    if (hv && ha != 6) model_h(ha, hd);
    if (cv && ca != 6) model_c(ca, cd);
    @(negedge clk);
    h_we = 1'b0; c_we = 1'b0;
  endtask

  task automatic hw(input int a, input logic [31:0] d);
    both(1'b1, a, d, 1'b0, 0, '0);
  endtask

  task automatic cw(input int a, input logic [31:0] d);
    both(1'b0, 0, '0, 1'b1, a, d);
  endtask

  function automatic logic [31:0] exp_h(input int a);
    case (a)
      0: return m_h2c;
      1: return m_h2s;
      2: return m_c2h;
      3: return m_c2x;
      4: return {24'h0, m_hpw};
      5: return {16'h0, m_cpw};
      6: return {30'h0, hst};
      default: return {30'h0, hmsk};
    endcase
  endfunction

  function automatic logic [31:0] exp_c(input int a);
    case (a)
      0: return m_c2h;
      1: return m_c2s;
      2: return m_h2c;
      3: return m_h2x;
      4: return {16'h0, m_cpw};
      5: return {24'h0, m_hpw};
      6: return {30'h0, cst};
      default: return {30'h0, cmsk};
    endcase
  endfunction

  task automatic check_all(input string req);
    for (int a = 0; a < 8; a++) begin
      h_addr = 3'(a); c_addr = 3'(a);
      #1;
      total++;
      if (h_rdata !== exp_h(a)) begin
        bad++;
        $display("FAIL %s host addr %0d got %h exp %h", req, a, h_rdata, exp_h(a));
      end
      total++;
      if (c_rdata !== exp_c(a)) begin
        bad++;
        $display("FAIL %s cpu addr %0d got %h exp %h", req, a, c_rdata, exp_c(a));
      end
    end
    total++;
    if (h_irq !== |(hst & hmsk)) begin
      bad++;
      $display("FAIL %s/R9 h_irq got %b exp %b", req, h_irq, |(hst & hmsk));
    end
    total++;
    if (c_irq !== |(cst & cmsk)) begin
      bad++;
      $display("FAIL %s/R9 c_irq got %b exp %b", req, c_irq, |(cst & cmsk));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R2: plain message in each direction, sequence bit unchanged (0)
    hw(0, 32'h1234_5678);
    check_all("R2");
    cw(0, 32'h0bad_cafe);
    check_all("R2");

    // R3: read-only addresses on both sides
    hw(2, 32'hffff_ffff); hw(3, 32'hffff_ffff); hw(5, 32'hffff_ffff);
    cw(2, 32'hffff_ffff); cw(3, 32'hffff_ffff); cw(5, 32'hffff_ffff);
    check_all("R3");

    // enable interrupts so that irq lines are compared throughout
    hw(7, 32'h3); cw(7, 32'h3);
    check_all("R9");

    // host-to-CPU sequence sweep: 0,0,1,1,0,0,1,1
    for (int i = 0; i < 8; i++) begin
      logic tg;
      logic chg;
      tg = 1'(i >> 1);
      chg = (tg != m_h2c[31]);
      hw(1, 32'ha000_0000 + 32'(i));
      hw(0, {tg, 31'(32'h0101_0101 * (i + 1))});
      check_all(chg ? "R4/R6" : "R5/R6");
      if (i % 2 == 1) begin
        cw(6, 32'h1);
        check_all("R8");
      end
    end

    // CPU-to-host sequence sweep
    for (int i = 0; i < 8; i++) begin
      logic tg;
      logic chg;
      tg = 1'(i >> 1);
      chg = (tg != m_c2h[31]);
      cw(1, 32'h5000_0000 + 32'(i * 3));
      cw(0, {tg, 31'(32'h0202_0303 * (i + 2))});
      check_all(chg ? "R4/R6" : "R5/R6");
      if (i % 2 == 0) begin
        hw(6, 32'h1);
        check_all("R8");
      end
    end

    // power registers, junk in upper bits
    for (int i = 0; i < 6; i++) begin
      hw(4, 32'hffff_ff00 | 32'((i * 8'h45) & 8'hff));
      check_all("R7");
      cw(4, 32'hfff0_0000 | 32'((i * 16'h4321) & 16'hffff));
      check_all("R7");
    end

    // mask sweep with both status bits set on both sides
    hw(6, 32'h3); cw(6, 32'h3);
    hw(0, m_h2c ^ 32'h8000_0000);
    hw(4, {24'h0, m_hpw ^ 8'h80});
    cw(0, m_c2h ^ 32'h8000_0000);
    cw(4, {16'h0, m_cpw ^ 16'h8000});
    for (int m = 0; m < 4; m++) begin
      hw(7, 32'(m)); cw(7, 32'(m));
      check_all("R9");
    end
    for (int m = 0; m < 4; m++) begin
      cw(6, 32'h2);
      check_all("R8");
      cw(7, 32'(m));
      check_all("R9");
      cw(4, {16'h0, m_cpw ^ 16'h8000});
      cw(0, m_c2h ^ 32'h8000_0000);
      hw(6, 32'(m));
      check_all("R8");
    end

    // R8: writing zeros keeps status
    hw(4, {24'h0, m_hpw ^ 8'h80});
    cw(6, 32'h0);
    check_all("R8");

    // R8: same-cycle flip and clear, set wins
    both(1'b1, 0, m_h2c ^ 32'h8000_0000, 1'b1, 6, 32'h3);
    check_all("R8");
    both(1'b1, 4, {24'h0, m_hpw ^ 8'h80}, 1'b1, 6, 32'h3);
    check_all("R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule